// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block collects level-sensitive interrupt requests from two groups of sources and presents one level interrupt line to a processor. The primary group has 40 sources. The secondary group has 32 sources, and it does not reach the processor directly. Any pending and enabled secondary source instead raises primary source 0. Each source keeps a pending bit. Each group has an enable mask that software changes only through separate write-one-to-set and write-one-to-clear strobes. A write-one-to-clear acknowledge register drops pending bits once their sources have gone low.

A priority index register reports which enabled, pending primary source should be served first. There are 40 priority channels. A channel-map table assigns one source number to each channel, and the lowest channel whose assigned source is active wins. Software reads the index, services that source, and acknowledges it. When the index is 0, software acknowledges primary 0 and scans the secondary status from bit 0 upward.

The register port is a simple single-cycle 32-bit request port. Addresses are word addresses, so word address = byte offset / 4. Read data is registered.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, all pending and enable bits are 0, `irq_o` is low, the index reads 0, and channel-map entry c holds c.
- R2: A primary pending bit becomes 1 on the first clock edge at which its source input is high. Status words at word addresses 0x00 (sources 0..31) and 0x01 (sources 32..39 in bits [7:0]) return the raw pending bits whatever the enables hold.
- R3: Writing ones to word 0x04/0x05 clears the matching primary pending bits, but only for sources whose input is low in that cycle. A source that is still high stays pending. Zero bits leave their pending bits unchanged.
- R4: Writing ones to word 0x08/0x09 sets enable bits, and writing ones to word 0x0C/0x0D clears them. Zero bits have no effect. Reading 0x08/0x09 returns the enable bits.
- R5: Only bits [7:0] of the second primary word exist. Its higher bits read as 0, and writes to them are ignored.
- R6: `irq_o` is high exactly when at least one primary source is both pending and enabled. It follows the state registers with no further delay.
- R7: Reading word 0x10 returns in bits [5:0] the source number held by the lowest channel whose source is pending and enabled. It reads 0 when no such channel exists. An entry holding a number of 40 or more never matches.
- R8: Channel-map entry c sits at word address 0x80 + c and stores the low 6 bits of the written data. Remapping changes which source the index reports.
- R9: Secondary status is at word 0x20, acknowledge at 0x22, enable-set at 0x24 (which also reads back the enables) and enable-clear at 0x26. They follow the same write-one and level rules as the primary group.
- R10: Primary source 0 becomes pending on the edge after any secondary source is both pending and enabled. Secondary sources that are disabled do not set it.
- R11: Read data appears on `bus_rdata_o` on the edge after the read request. It is 0 in every cycle that does not follow a read, and 0 for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pri_src_i | input | NUM_PRI-1 | Primary source levels 1..NUM_PRI-1 (source 0 is the cascade) |
| sec_src_i | input | NUM_SEC | Secondary source levels |
| bus_req_i | input | 1 | Register access request, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
Source inputs and register writes act at the clock edge where they are sampled, so pending bits, enables and `irq_o` are due in the half cycle right after that edge. The cascade adds one further edge before primary 0 follows a secondary source. Read data is due one edge after the request and reflects the state as it stood before that edge. The bench's behavioural model updates its own state at each rising edge in that same order, and both `irq_o` and `bus_rdata_o` are compared against it at every falling edge. Any early or late response therefore shows up as a miscompare in the cycle concerned.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 10;
   localparam int unsigned PAD_W  = 64;

   // word addresses of the register groups
   localparam logic [ADDR_W-1:0] A_PRI_STAT = 10'h000;
   localparam logic [ADDR_W-1:0] A_PRI_ACK  = 10'h004;
   localparam logic [ADDR_W-1:0] A_PRI_SET  = 10'h008;
   localparam logic [ADDR_W-1:0] A_PRI_CLR  = 10'h00C;
   localparam logic [ADDR_W-1:0] A_INDEX    = 10'h010;
   localparam logic [ADDR_W-1:0] A_SEC_STAT = 10'h020;
   localparam logic [ADDR_W-1:0] A_SEC_ACK  = 10'h022;
   localparam logic [ADDR_W-1:0] A_SEC_SET  = 10'h024;
   localparam logic [ADDR_W-1:0] A_SEC_CLR  = 10'h026;
   localparam logic [ADDR_W-1:0] A_CHMAP    = 10'h080;

   // true when a lies in the four-word bank starting at base
   function automatic logic bank_hit(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
      return a[ADDR_W-1:2] == base[ADDR_W-1:2];
   endfunction

endpackage

// File: rtl/cirq_pend_bank.sv
module cirq_pend_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] src_i,
   input  logic         ack_we_i,
   input  logic         set_we_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] pend_o,
   output logic [W-1:0] en_o
);

   logic [W-1:0] ack_bits, set_bits, clr_bits;

   assign ack_bits = ack_we_i ? mask_i : '0;
   assign set_bits = set_we_i ? mask_i : '0;
   assign clr_bits = clr_we_i ? mask_i : '0;

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic pend_q, en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
         end else begin
            // a high level always wins over an acknowledge
            pend_q <= src_i[b] | (pend_q & ~ack_bits[b]);
            en_q   <= (en_q | set_bits[b]) & ~clr_bits[b];
         end
      end
      assign pend_o[b] = pend_q;
      assign en_o[b]   = en_q;
   end

endmodule

// File: rtl/cirq_chan_map.sv
module cirq_chan_map #(
   parameter int unsigned NCH   = 40,
   parameter int unsigned SRC_W = 6
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      we_i,
   input  logic [SRC_W-1:0]          idx_i,
   input  logic [SRC_W-1:0]          data_i,
   output logic [NCH-1:0][SRC_W-1:0] map_o
);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SRC_W-1:0] ent_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ent_q <= SRC_W'(c);
         end else if (we_i && (idx_i == SRC_W'(c))) begin
            ent_q <= data_i;
         end
      end
      assign map_o[c] = ent_q;
   end

endmodule

// File: rtl/cirq_prio_pick.sv
module cirq_prio_pick #(
   parameter int unsigned NCH   = 40,
   parameter int unsigned SRC_W = 6
) (
   input  logic [NCH-1:0]            active_i,
   input  logic [NCH-1:0][SRC_W-1:0] map_i,
   output logic [SRC_W-1:0]          idx_o
);

   localparam int unsigned SPAN = 2 ** SRC_W;

   logic [SPAN-1:0] act_pad;

   // padding with zeros makes out-of-range map entries never match
   assign act_pad = SPAN'(active_i);

   always_comb begin
      idx_o = '0;
      for (int c = NCH - 1; c >= 0; c--) begin
         if (act_pad[map_i[c]]) begin
            idx_o = map_i[c];
         end
      end
   end

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
   import cirq_pkg::*;
#(
   parameter int unsigned NUM_PRI = 40,
   parameter int unsigned NUM_SEC = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PRI-1:1]  pri_src_i,
   input  logic [NUM_SEC-1:0]  sec_src_i,
   input  logic                bus_req_i,
   input  logic                bus_we_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                irq_o
);

   localparam int unsigned SRC_W     = $clog2(NUM_PRI);
   localparam int unsigned PRI_WORDS = (NUM_PRI + 31) / 32;
   localparam logic [ADDR_W-1:0] MAP_END = A_CHMAP + ADDR_W'(NUM_PRI);

   initial begin : param_chk
      assert (NUM_PRI >= 2 && NUM_PRI <= PAD_W)
         else $fatal(1, "NUM_PRI must lie in 2..64");
      assert (NUM_SEC >= 1 && NUM_SEC <= DATA_W)
         else $fatal(1, "NUM_SEC must lie in 1..32");
   end

   // decode
   logic              wr_en, rd_en, word_ok;
   logic [1:0]        word_sel;
   logic [PAD_W-1:0]  wide_wdata;
   logic [NUM_PRI-1:0] pri_mask;
   logic [NUM_SEC-1:0] sec_mask;
   logic              pri_ack_we, pri_set_we, pri_clr_we;
   logic              sec_ack_we, sec_set_we, sec_clr_we;
   logic              map_hit, map_we;
   logic [SRC_W-1:0]  map_idx;

   assign wr_en      = bus_req_i & bus_we_i;
   assign rd_en      = bus_req_i & ~bus_we_i;
   assign word_sel   = bus_addr_i[1:0];
   assign word_ok    = 32'(word_sel) < PRI_WORDS;
   assign wide_wdata = PAD_W'(bus_wdata_i) << {word_sel, 5'd0};
   assign pri_mask   = wide_wdata[NUM_PRI-1:0];
   assign sec_mask   = bus_wdata_i[NUM_SEC-1:0];

   assign pri_ack_we = wr_en & word_ok & bank_hit(bus_addr_i, A_PRI_ACK);
   assign pri_set_we = wr_en & word_ok & bank_hit(bus_addr_i, A_PRI_SET);
   assign pri_clr_we = wr_en & word_ok & bank_hit(bus_addr_i, A_PRI_CLR);
   assign sec_ack_we = wr_en & (bus_addr_i == A_SEC_ACK);
   assign sec_set_we = wr_en & (bus_addr_i == A_SEC_SET);
   assign sec_clr_we = wr_en & (bus_addr_i == A_SEC_CLR);

   assign map_hit = (bus_addr_i >= A_CHMAP) && (bus_addr_i < MAP_END);
   assign map_we  = wr_en & map_hit;
   assign map_idx = SRC_W'(bus_addr_i - A_CHMAP);

   // secondary group
   logic [NUM_SEC-1:0] sec_pend, sec_en;

   cirq_pend_bank #(.W(NUM_SEC)) sec_bank_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (sec_src_i),
      .ack_we_i(sec_ack_we),
      .set_we_i(sec_set_we),
      .clr_we_i(sec_clr_we),
      .mask_i  (sec_mask),
      .pend_o  (sec_pend),
      .en_o    (sec_en)
   );

   // primary group, slot 0 fed by the secondary group
   logic                cascade;
   logic [NUM_PRI-1:0]  pri_in, pri_pend, pri_en, pri_active;

   assign cascade = |(sec_pend & sec_en);
   assign pri_in  = {pri_src_i, cascade};

   cirq_pend_bank #(.W(NUM_PRI)) pri_bank_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (pri_in),
      .ack_we_i(pri_ack_we),
      .set_we_i(pri_set_we),
      .clr_we_i(pri_clr_we),
      .mask_i  (pri_mask),
      .pend_o  (pri_pend),
      .en_o    (pri_en)
   );

   assign pri_active = pri_pend & pri_en;
   assign irq_o      = |pri_active;

   // priority channels
   logic [NUM_PRI-1:0][SRC_W-1:0] chan_map;
   logic [SRC_W-1:0]              pri_idx;

   cirq_chan_map #(.NCH(NUM_PRI), .SRC_W(SRC_W)) chan_map_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (map_we),
      .idx_i (map_idx),
      .data_i(bus_wdata_i[SRC_W-1:0]),
      .map_o (chan_map)
   );

   cirq_prio_pick #(.NCH(NUM_PRI), .SRC_W(SRC_W)) prio_i (
      .active_i(pri_active),
      .map_i   (chan_map),
      .idx_o   (pri_idx)
   );

   // read path
   logic [PAD_W-1:0]  pend_pad, en_pad;
   logic [DATA_W-1:0] rd_next;

   assign pend_pad = PAD_W'(pri_pend);
   assign en_pad   = PAD_W'(pri_en);

   always_comb begin
      rd_next = '0;
      if (word_ok && bank_hit(bus_addr_i, A_PRI_STAT)) begin
         rd_next = DATA_W'(pend_pad >> {word_sel, 5'd0});
      end else if (word_ok && bank_hit(bus_addr_i, A_PRI_SET)) begin
         rd_next = DATA_W'(en_pad >> {word_sel, 5'd0});
      end else if (bus_addr_i == A_INDEX) begin
         rd_next = DATA_W'(pri_idx);
      end else if (bus_addr_i == A_SEC_STAT) begin
         rd_next = DATA_W'(sec_pend);
      end else if (bus_addr_i == A_SEC_SET) begin
         rd_next = DATA_W'(sec_en);
      end else if (map_hit) begin
         rd_next = DATA_W'(chan_map[map_idx]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bus_rdata_o <= '0;
      end else begin
         bus_rdata_o <= rd_en ? rd_next : '0;
      end
   end

endmodule

// File: rtl/cirq_chk.sv
module cirq_chk #(
   parameter int unsigned NUM_PRI = 40,
   parameter int unsigned NUM_SEC = 32,
   parameter int unsigned SRC_W   = 6
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_PRI-1:1] pri_src_i,
   input logic [NUM_SEC-1:0] sec_src_i,
   input logic [NUM_PRI-1:0] pri_pend,
   input logic [NUM_PRI-1:0] pri_en,
   input logic [NUM_SEC-1:0] sec_pend,
   input logic [NUM_SEC-1:0] sec_en,
   input logic [SRC_W-1:0]   pri_idx,
   input logic               bus_req_i,
   input logic               bus_we_i,
   input logic [31:0]        bus_rdata_o,
   input logic               irq_o
);

   // R2
   pri_level_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((pri_pend[NUM_PRI-1:1] & $past(pri_src_i)) == $past(pri_src_i)));

   // R9
   sec_level_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((sec_pend & $past(sec_src_i)) == $past(sec_src_i)));

   // R10
   cascade_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(sec_pend & sec_en)) |=> pri_pend[0]);

   // R7
   idx_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o |-> (pri_idx == '0));

   // R7
   idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (32'(pri_idx) < NUM_PRI));

   // R6
   irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (|pri_en));

   // R11
   rdata_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(bus_req_i && !bus_we_i) |-> (bus_rdata_o == '0));

endmodule

bind casc_irq_ctrl cirq_chk #(
   .NUM_PRI(NUM_PRI),
   .NUM_SEC(NUM_SEC),
   .SRC_W  (SRC_W)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .pri_src_i  (pri_src_i),
   .sec_src_i  (sec_src_i),
   .pri_pend   (pri_pend),
   .pri_en     (pri_en),
   .sec_pend   (sec_pend),
   .sec_en     (sec_en),
   .pri_idx    (pri_idx),
   .bus_req_i  (bus_req_i),
   .bus_we_i   (bus_we_i),
   .bus_rdata_o(bus_rdata_o),
   .irq_o      (irq_o)
);

// File: tb/casc_irq_ctrl_tb.sv
module casc_irq_ctrl_tb_top;

   localparam int NP = 40;
   localparam int NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:1] psrc = '0;
   logic [NS-1:0] ssrc = '0;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [9:0]    addr = '0;
   logic [31:0]   wd = '0;
   logic [31:0]   rdata;
   logic          irq;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string tag_r = "R11";

   always #5 clk = ~clk;

   casc_irq_ctrl dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .pri_src_i  (psrc),
      .sec_src_i  (ssrc),
      .bus_req_i  (req),
      .bus_we_i   (we),
      .bus_addr_i (addr),
      .bus_wdata_i(wd),
      .bus_rdata_o(rdata),
      .irq_o      (irq)
   );

   // behavioural reference state
   logic [63:0] pp, pe;
   logic [31:0] sp, se;
   int          mp [NP];
   logic [31:0] exp_rd = '0;
   string       exp_tag = "R1";
   localparam logic [63:0] LIM = (64'd1 << NP) - 64'd1;

   function automatic int best();
      for (int c = 0; c < NP; c++) begin
         if (mp[c] < NP && pp[mp[c]] && pe[mp[c]]) return mp[c];
      end
      return 0;
   endfunction

   function automatic logic [31:0] mread(int a);
      if (a == 0)  return pp[31:0];
      if (a == 1)  return pp[63:32];
      if (a == 8)  return pe[31:0];
      if (a == 9)  return pe[63:32];
      if (a == 16) return 32'(best());
      if (a == 32) return sp;
      if (a == 36) return se;
      if (a >= 128 && a < 128 + NP) return 32'(mp[a-128]);
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pp = '0; pe = '0; sp = '0; se = '0; exp_rd = '0;
         for (int c = 0; c < NP; c++) mp[c] = c;
      end else begin
         int          a;
         logic [63:0] m, ap, stp, clp;
         logic [31:0] as_, sts, cls;
         logic        casc;
         a = int'(addr);
         exp_rd  = (req && !we) ? mread(a) : 32'd0;
         exp_tag = tag_r;
         casc = |(sp & se);
         m = ({32'd0, wd} << (32 * (a % 4))) & LIM;
         ap = '0; stp = '0; clp = '0; as_ = '0; sts = '0; cls = '0;
         if (req && we) begin
            if ((a % 4) < 2) begin
               if (a / 4 == 1) ap  = m;
               if (a / 4 == 2) stp = m;
               if (a / 4 == 3) clp = m;
            end
            if (a == 34) as_ = wd;
            if (a == 36) sts = wd;
            if (a == 38) cls = wd;
            if (a >= 128 && a < 128 + NP) mp[a-128] = int'(wd[5:0]);
         end
         pp = ({24'd0, psrc, casc}) | (pp & ~ap);
         pe = (pe | stp) & ~clp;
         sp = ssrc | (sp & ~as_);
         se = (se | sts) & ~cls;
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         n_vec++;
         if (irq !== |(pp & pe)) begin
            n_bad++;
            $display("FAIL R6 irq_o actual %0b expected %0b", irq, |(pp & pe));
         end
         n_vec++;
         if (rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata actual %08h expected %08h", exp_tag, rdata, exp_rd);
         end
      end
   end

   task automatic idle(int n = 1);
      repeat (n) begin
         @(negedge clk);
         req = 1'b0; we = 1'b0;
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 10'(a); wd = d;
   endtask

   task automatic rd(int a, string t);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = 10'(a); wd = '0; tag_r = t;
   endtask

   task automatic srcs(logic [NP-1:1] p, logic [NS-1:0] s);
      @(negedge clk);
      req = 1'b0; psrc = p; ssrc = s;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, "R1"); rd(1, "R1"); rd(8, "R1"); rd(16, "R1");
      rd(32, "R1"); rd(36, "R1"); rd(128, "R1"); rd(128 + 39, "R8");
      // R2 raw pending with enables off
      srcs(39'(1) << 2 | 39'(1) << 34, '0);
      srcs('0, '0);
      rd(0, "R2"); rd(1, "R2");
      // R4, R6, R7
      wr(8, 32'h8); rd(16, "R7");
      wr(9, 32'h8); rd(16, "R7");
      wr(12, 32'h0); rd(8, "R4"); rd(9, "R4");
      wr(4, 32'h8); rd(0, "R3"); rd(16, "R7");
      // R3 acknowledge while the source is still high
      srcs(39'(1) << 34, '0);
      wr(5, 32'h8); rd(1, "R3");
      srcs('0, '0);
      wr(5, 32'h0); rd(1, "R3");
      wr(5, 32'h8); rd(1, "R3"); rd(16, "R7");
      // R5 upper word width
      wr(9, 32'hFFFF_FFFF); rd(9, "R5");
      wr(13, 32'hFFFF_FF00); rd(9, "R5");
      wr(13, 32'hFF); rd(9, "R5");
      // R8 remapping
      wr(8, 32'h408);
      srcs(39'(1) << 2 | 39'(1) << 9, '0);
      srcs('0, '0);
      rd(16, "R8");
      wr(128, 32'd10); rd(128, "R8"); rd(16, "R8");
      wr(128 + 10, 32'd63); rd(16, "R8");
      wr(128, 32'hFFFF_FFC0); rd(128, "R8"); rd(16, "R8");
      // R9, R10 secondary group and cascade
      wr(4, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF);
      srcs('0, 32'h80);
      srcs('0, '0);
      rd(32, "R9"); idle(2); rd(0, "R10");
      wr(36, 32'h81); rd(36, "R9"); idle(2); rd(0, "R10");
      wr(8, 32'h1); rd(16, "R10");
      wr(34, 32'h80); wr(4, 32'h1); idle(2); rd(32, "R9"); rd(0, "R10");
      wr(38, 32'h80); rd(36, "R9");
      rd(48, "R11"); rd(200, "R11");
      // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         int k;
         k = $urandom_range(0, 9);
         if (k < 2) begin
            srcs(39'(($urandom_range(0, 3) == 0) ? (64'd1 << $urandom_range(1, 39)) : 64'd0),
                 ($urandom_range(0, 3) == 0) ? (32'd1 << $urandom_range(0, 31)) : 32'd0);
         end else if (k < 6) begin
            int sel;
            int wa [12] = '{4, 5, 8, 9, 12, 13, 34, 36, 38, 128, 140, 167};
            sel = $urandom_range(0, 11);
            wr(wa[sel], $urandom());
         end else if (k < 9) begin
            int ra [9] = '{0, 1, 8, 9, 16, 32, 36, 131, 7};
            rd(ra[$urandom_range(0, 8)], "R7");
         end else begin
            idle();
         end
      end
      idle(3);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired, actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule